// File: doc/BRIEF.md
# Motion Compensation Reference Tile Cache

This block is a read-only cache between the motion compensation stage of a video decoder and the external memory that holds the reference pictures. The requester asks for reference pixels by picture id, pixel column and pixel row. Each cache line holds one tile of the reference picture that is 8 pixels wide and 2 rows high. Each request returns one 8-pixel row of a tile. When motion-compensated blocks in P and B pictures overlap, they read the same reference pixels again. The cache serves those repeated reads locally, so the pixels are fetched from memory only once.

The set is chosen from the low bits of both the tile column and the tile row. Tiles that are next to each other horizontally or vertically therefore fall into different sets. A line is exactly one minimum memory burst. A miss issues one request on the memory port and takes two 64-bit beats, one tile row per beat. The requester is stalled until both beats have been written into the line. A flush input invalidates every line in one cycle, for use when the reference picture list changes. Two counters give the number of hits and misses so that a trace-replaying model can compare against them.

Top module: `mc_ref_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, and both counters are 0.
- R2: The tile column is x>>3 and the tile row is y>>1. The set number is {tile_row[1:0], tile_col[1:0]}, which gives 16 sets. All 16 tiles of any aligned 4x4 tile region can be resident at the same time.
- R3: The tag holds the picture id and the upper tile column and tile row bits. The same x and y in two different pictures are two separate lines.
- R4: A hit raises rsp_valid in the cycle after the request is accepted, and no memory request is made. rsp_data byte i (bits 8i+7:8i) is the pixel at column tile_col*8+i and row tile_row*2+y[0].
- R5: A miss makes exactly one memory request with mem_req_addr = {frame, tile_col, tile_row}, frame in the top bits. The memory then returns two beats: tile row 0 first, then tile row 1. rsp_valid rises in the cycle after the second beat is received, carrying the requested row.
- R6: From the acceptance of a missing request until its response, req_ready stays 0. While mem_req_valid waits for mem_req_ready, it stays high and mem_req_addr does not change.
- R7: Each set has four ways. A miss fills an invalid way first, taking the lowest-numbered invalid way. Otherwise it replaces the way chosen by a 3-bit pseudo-LRU tree: the root selects a half, and each leaf bit selects a way in its pair. Every hit and every fill points the tree away from the way just used.
- R8: A flush cycle invalidates all lines, so the next access to any previously resident tile misses.
- R9: Every accepted request adds one to exactly one of hit_count or miss_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when both are high |
| req_frame | input | F_W | Reference picture id |
| req_x | input | X_W | Pixel column |
| req_y | input | Y_W | Pixel row |
| rsp_valid | output | 1 | Response row valid for one cycle |
| rsp_data | output | 64 | Eight pixels, lowest column in the low byte |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | F_W+X_W-3+Y_W-1 | {frame, tile column, tile row} |
| mem_rsp_valid | input | 1 | Fill beat valid |
| mem_rsp_data | input | 64 | Fill beat, one tile row |
| hit_count | output | CNT_W | Accepted hits |
| miss_count | output | CNT_W | Accepted misses |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU tree has been driven into a chosen shape, because it takes several exact accesses that all map to one set. The stimulus flushes the cache and fills one set with four tiles spaced four tile columns apart. It then reorders hits to those tiles so that each eviction falls on a way that can be worked out by hand, and it confirms every eviction by observing which tile then misses. A memory model with added latency and gaps between beats keeps the stall window open for several cycles.

// File: rtl/mc_ref_cache.sv
module mc_ref_cache #(
  parameter int F_W   = 4,
  parameter int X_W   = 11,
  parameter int Y_W   = 10,
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [F_W-1:0]               req_frame,
  input  logic [X_W-1:0]               req_x,
  input  logic [Y_W-1:0]               req_y,
  output logic                         rsp_valid,
  output logic [63:0]                  rsp_data,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [F_W+X_W-3+Y_W-1-1:0]   mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [63:0]                  mem_rsp_data,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             miss_count
);
  localparam int TX_W   = X_W - 3;
  localparam int TY_W   = Y_W - 1;
  localparam int SX     = 2;
  localparam int SY     = 2;
  localparam int SET_W  = SX + SY;
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 4;
  localparam int TAG_W  = F_W + (TX_W - SX) + (TY_W - SY);
  localparam int ADDR_W = F_W + TX_W + TY_W;

  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_FILL0, S_FILL1} state_t;

  state_t            state;
  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tags [SETS][WAYS];
  logic [63:0]       dat  [SETS][WAYS][2];
  logic [2:0]        plru [SETS];

  logic [SET_W-1:0]  m_set;
  logic [1:0]        m_way;
  logic              m_row;
  logic [ADDR_W-1:0] m_addr;

  wire [TX_W-1:0]  in_col = req_x[X_W-1:3];
  wire [TY_W-1:0]  in_row = req_y[Y_W-1:1];
  wire [SET_W-1:0] in_set = {in_row[SY-1:0], in_col[SX-1:0]};
  wire [TAG_W-1:0] in_tag = {req_frame, in_col[TX_W-1:SX], in_row[TY_W-1:SY]};
  wire             unused_lsb = ^req_x[2:0];

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_MREQ);
  assign mem_req_addr  = m_addr;

  wire accept = req_valid && req_ready;

  logic       hit;
  logic [1:0] hit_way;
  logic [1:0] victim;
  logic       any_free;

  always_comb begin
    hit     = 1'b0;
    hit_way = 2'd0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[in_set][w] && tags[in_set][w] == in_tag) begin
        hit     = 1'b1;
        hit_way = 2'(w);
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    victim   = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[in_set][w]) begin
        any_free = 1'b1;
        victim   = 2'(w);
      end
    end
    if (!any_free)
      victim = plru[in_set][0] ? {1'b1, plru[in_set][2]} : {1'b0, plru[in_set][1]};
  end

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      m_set      <= '0;
      m_way      <= '0;
      m_row      <= 1'b0;
      m_addr     <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int s = 0; s < SETS; s++) plru[s] <= 3'b000;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (hit) begin
            hit_count     <= hit_count + 1'b1;
            rsp_valid     <= 1'b1;
            rsp_data      <= dat[in_set][hit_way][req_y[0]];
            plru[in_set]  <= touch(plru[in_set], hit_way);
          end else begin
            miss_count <= miss_count + 1'b1;
            m_set      <= in_set;
            m_way      <= victim;
            m_row      <= req_y[0];
            m_addr     <= {req_frame, in_col, in_row};
            state      <= S_MREQ;
          end
        end
        S_MREQ:  if (mem_req_ready) state <= S_FILL0;
        S_FILL0: if (mem_rsp_valid) state <= S_FILL1;
        S_FILL1: if (mem_rsp_valid) begin
          state        <= S_IDLE;
          rsp_valid    <= 1'b1;
          rsp_data     <= m_row ? mem_rsp_data : dat[m_set][m_way][0];
          plru[m_set]  <= touch(plru[m_set], m_way);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
    end else if (state == S_MREQ) begin
      vld[m_set][m_way] <= 1'b0;
    end else if (state == S_FILL1 && mem_rsp_valid) begin
      vld[m_set][m_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_MREQ)
      tags[m_set][m_way] <= {m_addr[ADDR_W-1 -: F_W], m_addr[TY_W+SX +: TX_W-SX], m_addr[SY +: TY_W-SY]};
    if (state == S_FILL0 && mem_rsp_valid)
      dat[m_set][m_way][0] <= mem_rsp_data;
    if (state == S_FILL1 && mem_rsp_valid)
      dat[m_set][m_way][1] <= mem_rsp_data;
  end
endmodule

module mc_ref_cache_chk #(
  parameter int F_W   = 4,
  parameter int X_W   = 11,
  parameter int Y_W   = 10,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic                       mem_req_valid,
  input logic                       mem_req_ready,
  input logic [F_W+X_W-3+Y_W-1-1:0] mem_req_addr,
  input logic [CNT_W-1:0]           hit_count,
  input logic [CNT_W-1:0]           miss_count
);
  wire [CNT_W:0] total = hit_count + miss_count;

  p_accept_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (total == $past(total) + 1'b1));

  p_hit_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> rsp_valid);

  p_ready_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_no_rsp_during_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && rsp_valid));
endmodule

bind mc_ref_cache mc_ref_cache_chk #(.F_W(F_W), .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_mc_ref_cache.sv
module tb_mc_ref_cache;
  localparam int F_W = 4, X_W = 11, Y_W = 10, CNT_W = 16;
  localparam int TX_W = X_W - 3, TY_W = Y_W - 1, A_W = F_W + TX_W + TY_W;

  logic clk = 0, rst_n = 0, flush = 0;
  logic req_valid = 0, req_ready;
  logic [F_W-1:0] req_frame = 0;
  logic [X_W-1:0] req_x = 0;
  logic [Y_W-1:0] req_y = 0;
  logic rsp_valid;
  logic [63:0] rsp_data;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [A_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic [CNT_W-1:0] hit_count, miss_count;

  int errors = 0, checks = 0, mem_reqs = 0, lat = 0, gap = 0;
  logic [A_W-1:0] last_addr = '0;

  always #5 clk = ~clk;

  mc_ref_cache #(.F_W(F_W), .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) dut (.*);

  function automatic logic [7:0] pix(int f, int x, int y);
    return 8'((f * 61 + x * 3 + y * 17) ^ (x >> 2) ^ (y << 3));
  endfunction

  function automatic logic [63:0] row_word(int f, int tc, int ty);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = pix(f, tc * 8 + i, ty);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [A_W-1:0] cap;
        repeat (lat) @(negedge clk);
        mem_req_ready = 1;
        cap = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 0;
        mem_reqs++;
        last_addr = cap;
        for (int b = 0; b < 2; b++) begin
          repeat (gap) @(negedge clk);
          mem_rsp_valid = 1;
          mem_rsp_data = row_word(int'(cap[A_W-1 -: F_W]), int'(cap[TY_W +: TX_W]),
                                  int'(cap[TY_W-1:0]) * 2 + b);
          @(negedge clk);
          mem_rsp_valid = 0;
        end
      end
    end
  end

  task automatic access(input int f, input int x, input int y, input bit exp_hit, input string req);
    int h0, m0, q0, n;
    bit ready_seen;
    logic [A_W-1:0] exp_addr;
    h0 = int'(hit_count); m0 = int'(miss_count); q0 = mem_reqs;
    exp_addr = {F_W'(f), TX_W'(x >> 3), TY_W'(y >> 1)};
    @(negedge clk);
    req_valid = 1; req_frame = F_W'(f); req_x = X_W'(x); req_y = Y_W'(y);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0; ready_seen = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) ready_seen = 1;
      @(negedge clk);
      n++;
    end
    check(rsp_valid && rsp_data == row_word(f, x >> 3, y),
          req, "response row", rsp_data, row_word(f, x >> 3, y));
    check(int'(hit_count) == h0 + (exp_hit ? 1 : 0) && int'(miss_count) == m0 + (exp_hit ? 0 : 1),
          "R9", exp_hit ? "hit counted" : "miss counted",
          {32'(hit_count), 32'(miss_count)}, {32'(h0 + (exp_hit ? 1 : 0)), 32'(m0 + (exp_hit ? 0 : 1))});
    if (exp_hit) begin
      check(n == 0 && mem_reqs == q0, "R4", "hit latency/no fetch", 64'(n), 64'd0);
    end else begin
      check(mem_reqs == q0 + 1 && last_addr == exp_addr, "R5", "fetch address",
            64'(last_addr), 64'(exp_addr));
      check(!ready_seen, "R6", "ready low during fill", 64'(ready_seen), 64'd0);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    check(req_ready && !rsp_valid && !mem_req_valid && hit_count == 0 && miss_count == 0,
          "R1", "reset outputs", {req_ready, rsp_valid, mem_req_valid, 16'(hit_count), 16'(miss_count)},
          {1'b1, 2'b00, 32'd0});
  endtask

  task automatic t_cold_then_hit();
    do_flush();
    access(0, 21, 4, 0, "R5");
    access(0, 17, 5, 1, "R4");
    access(0, 23, 4, 1, "R4");
  endtask

  task automatic t_index_spread();
    do_flush();
    for (int tr = 0; tr < 4; tr++)
      for (int tc = 0; tc < 4; tc++) access(1, 64 + tc * 8, 32 + tr * 2, 0, "R2");
    for (int tr = 0; tr < 4; tr++)
      for (int tc = 0; tc < 4; tc++) access(1, 64 + tc * 8 + 3, 32 + tr * 2 + 1, 1, "R2");
  endtask

  task automatic t_frame_tag();
    do_flush();
    access(2, 40, 6, 0, "R3");
    access(3, 40, 6, 0, "R3");
    access(2, 41, 7, 1, "R3");
    access(3, 41, 7, 1, "R3");
  endtask

  task automatic t_plru();
    do_flush();
    access(5, 0, 0, 0, "R7");
    access(5, 32, 0, 0, "R7");
    access(5, 64, 0, 0, "R7");
    access(5, 96, 0, 0, "R7");
    access(5, 0, 1, 1, "R7");
    access(5, 32, 1, 1, "R7");
    access(5, 64, 1, 1, "R7");
    access(5, 96, 1, 1, "R7");
    access(5, 0, 0, 1, "R7");
    access(5, 128, 0, 0, "R7");
    access(5, 0, 0, 1, "R7");
    access(5, 32, 0, 1, "R7");
    access(5, 96, 0, 1, "R7");
    access(5, 64, 0, 0, "R7");
    access(5, 32, 0, 1, "R7");
    access(5, 0, 0, 0, "R7");
  endtask

  task automatic t_flush();
    do_flush();
    access(6, 200, 100, 0, "R8");
    access(6, 200, 100, 1, "R8");
    do_flush();
    access(6, 200, 100, 0, "R8");
  endtask

  task automatic t_slow_mem();
    do_flush();
    lat = 3; gap = 2;
    access(7, 512, 301, 0, "R6");
    access(7, 519, 300, 1, "R6");
    lat = 0; gap = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cold_then_hit();
    t_index_spread();
    t_frame_tag();
    t_plru();
    t_flush();
    t_slow_mem();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule